// File: doc/BRIEF.md
# Presettable Up/Down Counter with Terminal Flags

A small binary counter whose value moves by one on each rising clock edge while its active-low enable is asserted. A single direction input picks up or down counting, and the value wraps at both ends of its range. An active-low load input forces the visible count to a parallel preset value at once, whatever the clock is doing. Counting then carries on from that value after load is released.

Two outputs let several stages be chained into a wider counter. The terminal flag is high when the count sits at the last value for the selected direction: all ones when counting up, zero when counting down. The ripple output is active low and pulses only during the low half of the clock, when the stage is enabled and at its terminal count. A following stage that shares the clock can take its enable from this stage's terminal flag combined with this stage's enable.

Top module: `updn_counter`

## Requirements
- R1: When rst_n is low at a rising clock edge, the stored count becomes 0; with load_n high, count reads 0 after that edge.
- R2: With cnt_en_n low, dir_down low (0 = up) and load_n high at a rising edge, count increases by one, and the largest value (15 at the default width of 4) wraps to 0.
- R3: With cnt_en_n low, dir_down high (1 = down) and load_n high at a rising edge, count decreases by one, and 0 wraps to the largest value.
- R4: With cnt_en_n high at a rising edge, count keeps its value. Changes on cnt_en_n or dir_down between edges leave count unchanged until the next rising edge.
- R5: While load_n is low, count equals preset without waiting for a clock edge. If preset stays steady across at least one rising edge with load_n low, counting resumes from that value at the first rising edge after load_n returns high.
- R6: term_flag is high exactly when (dir_down low and count at its largest value) or (dir_down high and count 0). It follows a change of dir_down at once, without a clock edge.
- R7: ripple_n is low only when term_flag is high, cnt_en_n is low and clk is low. It is high during the high phase of the clock.
- R8: Two stages that share clock and direction, with the upper enable taken as the lower cnt_en_n OR NOT lower term_flag, count as one 8-bit up/down counter across the carry and borrow points (low stage = bits 3:0).
- R9: After a load of 13, five enabled up edges give 14, 15, 0, 1, 2. Inhibited edges then hold 2, and five enabled down edges give 1, 0, 15, 14, 13. term_flag is high at 15 going up and at 0 going down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count moves on the rising edge, and the low phase gates ripple_n |
| rst_n | input | 1 | Synchronous active-low reset of the stored count |
| cnt_en_n | input | 1 | Active-low count enable |
| dir_down | input | 1 | Direction: 0 counts up, 1 counts down |
| load_n | input | 1 | Active-low asynchronous, level-sensitive preset |
| preset | input | WIDTH | Parallel preset value |
| count | output | WIDTH | Visible count value |
| term_flag | output | 1 | High at the terminal count for the current direction |
| ripple_n | output | 1 | Active-low cascade pulse during the clock low phase |

## Verification
A count change caused by enable and direction is due one rising edge after the inputs are driven. The bench drives inputs on the falling edge and compares the count on the next falling edge, after exactly one rising edge has passed. Load, the terminal flag and the ripple output are combinational. They are sampled 1 ns after the input that moves them, with no edge in between, and ripple_n is sampled in both clock phases. A seeded random mix of load, enable and direction is run on two chained stages against an 8-bit reference model, together with directed sweeps across the wrap points, a mid-cycle direction flip and the fixed load/up/inhibit/down sequence.

// File: rtl/updn_pkg.sv
// Package: shared types for the up/down counter.
// Assumes nothing beyond a single clock domain.
package updn_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;
endpackage

// File: rtl/updn_step.sv
// Module: updn_step
// Works out the value the counter takes at the next rising edge from the stored value,
// the active-low enable and the direction. Purely combinational; assumes cur is the
// stored register value, not the load-multiplexed output.
module updn_step #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_n,
    input  logic             dir_down,
    output logic [WIDTH-1:0] nxt
);
    import updn_pkg::*;

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    dir_e dir;

    // Map the raw direction pin onto the enumerated type.
    always_comb dir = dir_e'(dir_down);

    // Select hold, increment or decrement; natural wrap at both ends.
    always_comb begin
        if (en_n) begin
            nxt = cur;
        end else if (dir == DIR_DOWN) begin
            nxt = cur - ONE;
        end else begin
            nxt = cur + ONE;
        end
    end
endmodule

// File: rtl/updn_hold.sv
// Module: updn_hold
// Holds the count register and provides the asynchronous load path. While load_n is low
// the register captures preset at each rising edge, and the visible output passes preset
// straight through. Assumes preset is steady across at least one edge with load_n low,
// so that the register holds the loaded value when load_n is released.
module updn_hold #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] visible
);
    // State update: synchronous reset first, then load capture, then the step value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored <= '0;
        end else if (!load_n) begin
            stored <= preset;
        end else begin
            stored <= nxt;
        end
    end

    // Output multiplexer: the load level overrides the register with no clock.
    always_comb visible = load_n ? stored : preset;
endmodule

// File: rtl/updn_flags.sv
// Module: updn_flags
// Derives the terminal flag from the visible count and the direction pin, and the
// active-low ripple pulse from that flag, the clock level and, when GATE_EN is set,
// the enable. Combinational; assumes clk is a clean clock, as ripple_n follows it.
module updn_flags #(
    parameter int WIDTH   = 4,
    parameter bit GATE_EN = 1'b1
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] count,
    input  logic             dir_down,
    input  logic             en_n,
    output logic             term,
    output logic             ripple_n
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic at_top;
    logic at_bot;

    // Detect both ends of the range.
    always_comb begin
        at_top = (count == TOP);
        at_bot = (count == '0);
    end

    // Pick the end that matters for the current direction.
    always_comb term = dir_down ? at_bot : at_top;

    generate
        if (GATE_EN) begin : g_gated
            // Pulse low only for an enabled stage in the clock low phase.
            always_comb ripple_n = ~(term & ~en_n & ~clk);
        end else begin : g_plain
            // Pulse low in the clock low phase whatever the enable.
            always_comb ripple_n = ~(term & ~clk);
        end
    endgenerate
endmodule

// File: rtl/updn_counter.sv
// Module: updn_counter (top)
// Presettable up/down counter with terminal and ripple cascade outputs. Ties together
// the step logic, the register with load override and the flag logic.
// Assumes a single clock and a synchronous active-low reset.
module updn_counter #(
    parameter int WIDTH   = 4,
    parameter bit GATE_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en_n,
    input  logic             dir_down,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] count,
    output logic             term_flag,
    output logic             ripple_n
);
    logic [WIDTH-1:0] stored;
    logic [WIDTH-1:0] nxt;

    updn_step #(.WIDTH(WIDTH)) u_step (
        .cur      (stored),
        .en_n     (cnt_en_n),
        .dir_down (dir_down),
        .nxt      (nxt)
    );

    updn_hold #(.WIDTH(WIDTH)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_n  (load_n),
        .preset  (preset),
        .nxt     (nxt),
        .stored  (stored),
        .visible (count)
    );

    updn_flags #(.WIDTH(WIDTH), .GATE_EN(GATE_EN)) u_flags (
        .clk      (clk),
        .count    (count),
        .dir_down (dir_down),
        .en_n     (cnt_en_n),
        .term     (term_flag),
        .ripple_n (ripple_n)
    );
endmodule

// File: rtl/updn_counter_chk.sv
// Module: updn_counter_chk
// Property checker bound to every updn_counter instance. Observes ports only.
module updn_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en_n,
    input logic             dir_down,
    input logic             load_n,
    input logic [WIDTH-1:0] preset,
    input logic [WIDTH-1:0] count,
    input logic             term_flag,
    input logic             ripple_n
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    // R1: a reset edge leaves zero, unless the load path overrides the output.
    a_r1_reset_zero: assert property (@(posedge clk)
        (rst_n === 1'b0) |=> (!load_n || count == '0));

    // R2: an enabled up edge adds one.
    a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !dir_down) |=>
        (!load_n || count == WIDTH'($past(count) + 1'b1)));

    // R3: an enabled down edge subtracts one.
    a_r3_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && dir_down) |=>
        (!load_n || count == WIDTH'($past(count) - 1'b1)));

    // R4: a disabled edge holds the count.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en_n) |=> (!load_n || $stable(count)));

    // R5: a load held across an edge is kept once load is released.
    a_r5_load_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && cnt_en_n) |=> (!load_n || count == $past(preset)));

    // R6: an enabled edge at the up terminal count lands on zero.
    a_r6_term_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !dir_down && term_flag) |=>
        (!load_n || count == '0));

    // R6: an enabled edge at the down terminal count lands on the top value.
    a_r6_term_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && dir_down && term_flag) |=>
        (!load_n || count == TOP));

    // R7: ripple stays high through the clock high phase.
    a_r7_ripple_high_phase: assert property (@(negedge clk) disable iff (!rst_n)
        ripple_n);

    // R7: a low ripple pulse requires the terminal flag and the enable.
    a_r7_ripple_needs_term: assert property (@(posedge clk) disable iff (!rst_n)
        !ripple_n |-> (term_flag && !cnt_en_n));
endmodule

bind updn_counter updn_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en_n  (cnt_en_n),
    .dir_down  (dir_down),
    .load_n    (load_n),
    .preset    (preset),
    .count     (count),
    .term_flag (term_flag),
    .ripple_n  (ripple_n)
);

// File: tb/updn_counter_tb.sv
// Bench: two chained counter stages checked against an 8-bit reference model.
module updn_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       en_n;
    logic       dn;
    logic       ld_n;
    logic [7:0] pre;
    logic [3:0] cnt_lo;
    logic [3:0] cnt_hi;
    logic       term_lo;
    logic       term_hi;
    logic       rip_lo;
    logic       rip_hi;
    logic       en_hi_n;
    logic [7:0] model;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    // Cascade glue (R8): the upper stage moves only when the lower is enabled and terminal.
    assign en_hi_n = en_n | ~term_lo;

    updn_counter u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en_n(en_n), .dir_down(dn), .load_n(ld_n),
        .preset(pre[3:0]), .count(cnt_lo), .term_flag(term_lo), .ripple_n(rip_lo)
    );

    updn_counter u_hi (
        .clk(clk), .rst_n(rst_n), .cnt_en_n(en_hi_n), .dir_down(dn), .load_n(ld_n),
        .preset(pre[7:4]), .count(cnt_hi), .term_flag(term_hi), .ripple_n(rip_hi)
    );

    function automatic logic [7:0] next_model(logic [7:0] m, logic r_n, logic l_n,
                                              logic e_n, logic d, logic [7:0] p);
        if (!r_n)      return 8'd0;
        else if (!l_n) return p;
        else if (!e_n) return d ? m - 8'd1 : m + 8'd1;
        else           return m;
    endfunction

    function automatic logic exp_term(logic [3:0] v, logic d);
        return d ? (v == 4'd0) : (v == 4'd15);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge,
    // check at the next falling edge.
    task automatic tick(logic e_n, logic d, logic l_n, logic [7:0] p);
        en_n = e_n; dn = d; ld_n = l_n; pre = p;
        #1;
        if (!l_n) chk("R5 load passes preset without an edge", {cnt_hi, cnt_lo}, p);
        chk("R7 ripple low in clock low phase", rip_lo,
            !(exp_term(cnt_lo, d) && !e_n));
        @(posedge clk);
        model = next_model(model, rst_n, l_n, e_n, d, p);
        #2;
        chk("R7 ripple high in clock high phase", rip_lo, 1);
        @(negedge clk);
        #1;
        chk("R2 R3 R4 R8 count", {cnt_hi, cnt_lo}, model);
        chk("R6 terminal flag", term_lo, exp_term(model[3:0], d));
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] r;
        int up_seq[5];
        int dn_seq[5];
        up_seq = '{14, 15, 0, 1, 2};
        dn_seq = '{1, 0, 15, 14, 13};
        r = $urandom(32'h5EED_0042);
        rst_n = 1'b0; en_n = 1'b1; dn = 1'b0; ld_n = 1'b1; pre = 8'd0; model = 8'hxx;
        @(negedge clk);
        tick(1'b0, 1'b0, 1'b1, 8'd0);
        tick(1'b0, 1'b0, 1'b1, 8'd0);
        chk("R1 reset value", {cnt_hi, cnt_lo}, 0);
        rst_n = 1'b1;

        // R9 reference sequence on the low stage.
        tick(1'b1, 1'b0, 1'b0, 8'd13);
        chk("R9 loaded 13", cnt_lo, 13);
        for (int i = 0; i < 5; i++) begin
            tick(1'b0, 1'b0, 1'b1, 8'd0);
            chk("R9 up sequence", cnt_lo, up_seq[i]);
            chk("R9 flag going up", term_lo, up_seq[i] == 15);
        end
        for (int i = 0; i < 2; i++) begin
            tick(1'b1, 1'b0, 1'b1, 8'd0);
            chk("R9 inhibit hold", cnt_lo, 2);
        end
        for (int i = 0; i < 5; i++) begin
            tick(1'b0, 1'b1, 1'b1, 8'd0);
            chk("R9 down sequence", cnt_lo, dn_seq[i]);
            chk("R9 flag going down", term_lo, dn_seq[i] == 0);
        end

        // R6: direction flip between edges moves the flag at once, not the count (R4).
        tick(1'b1, 1'b0, 1'b0, 8'h0F);
        tick(1'b1, 1'b0, 1'b1, 8'h00);
        chk("R6 flag at 15 going up", term_lo, 1);
        dn = 1'b1;
        #1;
        chk("R6 flag drops on direction flip", term_lo, 0);
        chk("R4 count unchanged by direction flip", cnt_lo, 15);
        en_n = 1'b0;
        #1;
        chk("R4 count unchanged by enable change", cnt_lo, 15);
        @(negedge clk);

        // R2 R8: 8-bit up sweep across the 255 -> 0 wrap.
        tick(1'b1, 1'b0, 1'b0, 8'hF0);
        for (int i = 0; i < 40; i++) tick(1'b0, 1'b0, 1'b1, 8'd0);
        chk("R2 R8 up wrap result", {cnt_hi, cnt_lo}, 8'h18);
        // R3 R8: down sweep back across the 0 -> 255 wrap.
        for (int i = 0; i < 60; i++) tick(1'b0, 1'b1, 1'b1, 8'd0);
        chk("R3 R8 down wrap result", {cnt_hi, cnt_lo}, 8'hDC);

        // Random mix against the model.
        for (int i = 0; i < 3000; i++) begin
            r = $urandom;
            if (r[30:24] == 7'd0) begin
                rst_n = 1'b0;
                tick(1'b0, r[5], 1'b1, r[15:8]);
                chk("R1 mid-run reset", {cnt_hi, cnt_lo}, 0);
                rst_n = 1'b1;
            end else begin
                tick(r[4:3] == 2'd0, r[5] ^ r[20] & r[21], r[2:0] != 3'd0, r[15:8]);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule